// File: doc/BRIEF.md
# Three-Pair Motor PWM Generator

This block drives six PWM outputs arranged as three pairs: channels 0/1 form pair A, 2/3 form pair B and 4/5 form pair C. Each pair has its own alignment select (center or edge) and its own pair-mode select (complementary or independent). Each channel has a duty value, and each of the three generators has a period value. Every generator raises a one-clock reload pulse in the first clock of each PWM cycle.

A timebase-mode input picks the counter arrangement. With one timebase, generator A's counter, period and alignment drive all three pairs, so all six outputs stay in lock-step. With three timebases, generators A, B and C each count their own period with their own alignment, and they are not synchronized to each other. Period, duty, alignment and pair mode are sampled only at a cycle boundary, so a new value never cuts a PWM cycle short.

Top module: `pwm3_gen`

## Requirements
- R1: While reset is held, all six PWM outputs and all three reload pulses are 0.
- R2: With alignment select 1 (edge) and period P≥1, a generator's cycle lasts P clocks. Its count runs 0,1,…,P-1. Its reload pulse is 1 only in the clock where the count is 0.
- R3: With alignment select 0 (center) and period P≥1, a cycle lasts 2P clocks. The count runs 0 up to P and then back down to 1. A channel is 1 while the count is below its duty, so the pulse is symmetric about the peak. The reload pulse marks the clock where the count is 0.
- R4: A duty of 0 holds a channel at 0. A nonzero duty at or above the active period holds it at 1. A period of 0 gives a one-clock cycle in either alignment.
- R5: With pair-mode select 0 (complementary), the odd channel is the inverse of the even channel. The odd channel's duty value has no effect.
- R6: With pair-mode select 1 (independent), each channel of the pair compares the count against its own duty.
- R7: With timebase mode 0, pairs B and C use generator A's period, count and alignment. Their own period and alignment inputs have no effect, and reload pulses B and C stay 0.
- R8: With timebase mode 1, generators A, B and C each run on their own period and alignment, and each has its own reload pulse.
- R9: A change to a period, duty, alignment or pair-mode input takes effect at the next cycle start of the generator driving that pair, never in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| multi_tb | input | 1 | 0: one shared timebase (generator A); 1: three independent timebases |
| align_sel | input | NPAIR | Per generator: 1 edge-aligned, 0 center-aligned |
| indep_sel | input | NPAIR | Per pair: 1 independent channels, 0 complementary |
| period_in | input | NPAIR*CW | Period of generator g in bits [g*CW +: CW] |
| duty_in | input | 2*NPAIR*CW | Duty of channel c in bits [c*CW +: CW] |
| pwm_out | output | 2*NPAIR | PWM channels; bit 2p is the even channel of pair p |
| reload_out | output | NPAIR | One-clock pulse at each generator's cycle start |

## Verification
The bench builds the block with its default values: CW = 8 and three pairs. Eight-bit values keep every cycle short, so each table row runs through many full cycles in a few dozen clocks. The rows use small periods (0, 1, 2, the turn at the peak of a center count) and duties of 0, equal to the period, and above the period. All of these boundaries are within reach of a short run. A directed sequence changes period, duty and pair mode in the middle of a cycle and confirms that the old values stay in force until the next reload.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  parameter int CW = 8;
  typedef logic [CW-1:0] cnt_t;

  // Edge mode: last clock of the cycle when the next count would reach the period.
  function automatic logic edge_last(cnt_t c, cnt_t p);
    return ({1'b0, c} + 1'b1) >= {1'b0, p};
  endfunction

  // Center mode: at or above the period the count turns back down.
  function automatic logic at_peak(cnt_t c, cnt_t p);
    return c >= p;
  endfunction

  // Center mode: last clock when the count would fall back to zero.
  function automatic logic center_last(cnt_t c, cnt_t p, logic down);
    return (c <= cnt_t'(1)) && (down || at_peak(c, p));
  endfunction

  // Output level from count, duty and period.
  function automatic logic pwm_level(cnt_t c, cnt_t d, cnt_t p);
    if (d == '0)     return 1'b0;
    else if (d >= p) return 1'b1;
    else             return c < d;
  endfunction
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  cnt_t per_in,
  input  logic edge_in,
  output cnt_t cnt_o,
  output cnt_t per_o,
  output logic last_o,
  output logic start_o
);
  cnt_t cnt_q, per_q;
  logic edge_q, down_q, start_q;

  assign last_o  = edge_q ? edge_last(cnt_q, per_q) : center_last(cnt_q, per_q, down_q);
  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign start_o = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      edge_q  <= 1'b0;
      down_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      per_q   <= '0;
      edge_q  <= 1'b0;
      down_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= last_o;
      if (last_o) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
        per_q  <= per_in;
        edge_q <= edge_in;
      end else if (edge_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (down_q || at_peak(cnt_q, per_q)) begin
        cnt_q  <= cnt_q - 1'b1;
        down_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm3_shadow.sv
module pwm3_shadow
  import pwm3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cnt_t duty_e_in,
  input  cnt_t duty_o_in,
  input  logic indep_in,
  output cnt_t sh_e,
  output cnt_t sh_o,
  output logic indep_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_e    <= '0;
      sh_o    <= '0;
      indep_q <= 1'b1;
    end else if (load) begin
      sh_e    <= duty_e_in;
      sh_o    <= duty_o_in;
      indep_q <= indep_in;
    end
  end
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    multi_tb,
  input  logic [NPAIR-1:0]        align_sel,
  input  logic [NPAIR-1:0]        indep_sel,
  input  logic [NPAIR*CW-1:0]     period_in,
  input  logic [2*NPAIR*CW-1:0]   duty_in,
  output logic [2*NPAIR-1:0]      pwm_out,
  output logic [NPAIR-1:0]        reload_out
);
  localparam int NCH = 2 * NPAIR;

  logic [NPAIR*CW-1:0] tb_cnt, tb_per;
  logic [NPAIR-1:0]    tb_last, tb_start;
  logic [NPAIR-1:0]    pair_load, pair_indep;
  logic [NCH*CW-1:0]   pair_sh;

  for (genvar g = 0; g < NPAIR; g++) begin : g_gen
    logic clr;
    cnt_t sel_cnt, sel_per;
    logic lvl_e, lvl_o;

    // Side generators sit cleared while the shared timebase is in use.
    if (g == 0) begin : g_main
      assign clr           = 1'b0;
      assign reload_out[g] = tb_start[g];
    end else begin : g_side
      assign clr           = !multi_tb;
      assign reload_out[g] = tb_start[g] & multi_tb;
    end

    pwm3_timebase u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .per_in  (period_in[g*CW +: CW]),
      .edge_in (align_sel[g]),
      .cnt_o   (tb_cnt[g*CW +: CW]),
      .per_o   (tb_per[g*CW +: CW]),
      .last_o  (tb_last[g]),
      .start_o (tb_start[g])
    );

    assign sel_cnt      = multi_tb ? tb_cnt[g*CW +: CW] : tb_cnt[0 +: CW];
    assign sel_per      = multi_tb ? tb_per[g*CW +: CW] : tb_per[0 +: CW];
    assign pair_load[g] = multi_tb ? tb_last[g]         : tb_last[0];

    pwm3_shadow u_sh (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (pair_load[g]),
      .duty_e_in (duty_in[(2*g)*CW +: CW]),
      .duty_o_in (duty_in[(2*g+1)*CW +: CW]),
      .indep_in  (indep_sel[g]),
      .sh_e      (pair_sh[(2*g)*CW +: CW]),
      .sh_o      (pair_sh[(2*g+1)*CW +: CW]),
      .indep_q   (pair_indep[g])
    );

    assign lvl_e = pwm_level(sel_cnt, pair_sh[(2*g)*CW +: CW], sel_per);
    assign lvl_o = pwm_level(sel_cnt, pair_sh[(2*g+1)*CW +: CW], sel_per);
    assign pwm_out[2*g]   = lvl_e;
    assign pwm_out[2*g+1] = pair_indep[g] ? lvl_o : !lvl_e;
  end
endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk
  import pwm3_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  multi_tb,
  input logic [2*NPAIR-1:0]    pwm_out,
  input logic [NPAIR-1:0]      reload_out,
  input logic [NPAIR*CW-1:0]   tb_cnt,
  input logic [NPAIR*CW-1:0]   tb_per,
  input logic [NPAIR-1:0]      pair_load,
  input logic [NPAIR-1:0]      pair_indep,
  input logic [2*NPAIR*CW-1:0] pair_sh
);
  a_r7_side_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_tb |-> (reload_out[NPAIR-1:1] == '0));

  for (genvar g = 0; g < NPAIR; g++) begin : g_chk
    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reload_out[g] |-> (tb_cnt[g*CW +: CW] == '0));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tb_cnt[g*CW +: CW] <= tb_per[g*CW +: CW]);

    a_r5_comp_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_indep[g] |-> (pwm_out[2*g+1] == !pwm_out[2*g]));

    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_sh[(2*g)*CW +: CW] == '0) |-> !pwm_out[2*g]);

    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_load[g] |=> ($stable(pair_sh[(2*g)*CW +: 2*CW]) && $stable(pair_indep[g])));
  end
endmodule

bind pwm3_gen pwm3_gen_chk #(.NPAIR(NPAIR)) u_chk (.*);

// File: tb/pwm3_gen_test.sv
`timescale 1ns/1ps
module pwm3_gen_test;
  import pwm3_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         multi_tb = 1'b0;
  logic [2:0]   align_sel = '0;
  logic [2:0]   indep_sel = '0;
  logic [23:0]  period_in = '0;
  logic [47:0]  duty_in = '0;
  logic [5:0]   pwm_out;
  logic [2:0]   reload_out;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwm3_gen uut (
    .clk(clk), .rst_n(rst_n), .multi_tb(multi_tb), .align_sel(align_sel),
    .indep_sel(indep_sel), .period_in(period_in), .duty_in(duty_in),
    .pwm_out(pwm_out), .reload_out(reload_out)
  );

  typedef struct packed {
    logic        multi;
    logic [2:0]  al;
    logic [2:0]  ind;
    logic [23:0] per;
    logic [47:0] duty;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{multi:1'b0, al:3'b001, ind:3'b000, per:{8'd7, 8'd3, 8'd5},
      duty:{8'd9, 8'd4, 8'd9, 8'd1, 8'd9, 8'd2}},
    '{multi:1'b0, al:3'b110, ind:3'b000, per:{8'd2, 8'd9, 8'd4},
      duty:{8'd0, 8'd4, 8'd0, 8'd3, 8'd7, 8'd1}},
    '{multi:1'b0, al:3'b001, ind:3'b111, per:{8'd1, 8'd1, 8'd6},
      duty:{8'd1, 8'd3, 8'd5, 8'd2, 8'd6, 8'd0}},
    '{multi:1'b1, al:3'b101, ind:3'b010, per:{8'd7, 8'd2, 8'd3},
      duty:{8'd0, 8'd5, 8'd1, 8'd2, 8'd0, 8'd2}},
    '{multi:1'b1, al:3'b011, ind:3'b001, per:{8'd1, 8'd0, 8'd4},
      duty:{8'd0, 8'd0, 8'd0, 8'd3, 8'd9, 8'd0}},
    '{multi:1'b1, al:3'b000, ind:3'b000, per:{8'd3, 8'd5, 8'd2},
      duty:{8'd8, 8'd2, 8'd8, 8'd4, 8'd8, 8'd1}}
  };
  string vec_req [NVEC] = '{"R2 R7", "R3 R7", "R6", "R8", "R4", "R5"};

  // Reference model: phase within the cycle plus values latched at cycle start.
  int  ph [3];
  int  pa [3];
  bit  ea [3];
  int  da [6];
  bit  ia [3];
  bit  fresh;

  function automatic int cyc_len(int p, bit e);
    if (p == 0) return 1;
    return e ? p : 2 * p;
  endfunction

  function automatic int count_at(int k, int p, bit e);
    if (e || k <= p) return k;
    return 2 * p - k;
  endfunction

  function automatic bit level(int v, int d, int p);
    if (d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    return v < d;
  endfunction

  task automatic model_step(output logic [8:0] exp);
    bit st [3];
    for (int g = 0; g < 3; g++) begin
      if (fresh || ph[g] >= cyc_len(pa[g], ea[g]) - 1) begin
        st[g] = 1'b1;
        ph[g] = 0;
        pa[g] = int'(period_in[g*8 +: 8]);
        ea[g] = align_sel[g];
      end else begin
        st[g] = 1'b0;
        ph[g] = ph[g] + 1;
      end
    end
    for (int p = 0; p < 3; p++) begin
      int s;
      bit e0;
      s = multi_tb ? p : 0;
      if (st[s]) begin
        da[2*p]   = int'(duty_in[(2*p)*8 +: 8]);
        da[2*p+1] = int'(duty_in[(2*p+1)*8 +: 8]);
        ia[p]     = indep_sel[p];
      end
      e0 = level(count_at(ph[s], pa[s], ea[s]), da[2*p], pa[s]);
      exp[2*p]   = e0;
      exp[2*p+1] = ia[p] ? level(count_at(ph[s], pa[s], ea[s]), da[2*p+1], pa[s]) : !e0;
    end
    exp[6] = st[0];
    exp[7] = multi_tb && st[1];
    exp[8] = multi_tb && st[2];
    fresh = 1'b0;
  endtask

  task automatic check(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {reload,pwm} got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // R1: outputs idle while reset is held.
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", {reload_out, pwm_out}, 9'b0);
    rst_n = 1'b1;
    fresh = 1'b1;
  endtask

  task automatic run_steps(string req, int n);
    logic [8:0] exp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_step(exp);
      check(req, {reload_out, pwm_out}, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int g = 0; g < 3; g++) begin ph[g] = 0; pa[g] = 0; ea[g] = 0; ia[g] = 1; end
    for (int c = 0; c < 6; c++) da[c] = 0;
    fresh = 1'b1;
    @(negedge clk);

    // Table of configurations, each run for many full cycles.
    for (int v = 0; v < NVEC; v++) begin
      multi_tb  = VECS[v].multi;
      align_sel = VECS[v].al;
      indep_sel = VECS[v].ind;
      period_in = VECS[v].per;
      duty_in   = VECS[v].duty;
      do_reset();
      run_steps(vec_req[v], 40);
    end

    // R9: values changed mid-cycle wait for the next cycle start.
    multi_tb  = 1'b0;
    align_sel = 3'b001;
    indep_sel = 3'b000;
    period_in = {8'd0, 8'd0, 8'd4};
    duty_in   = {8'd0, 8'd0, 8'd0, 8'd0, 8'd7, 8'd2};
    do_reset();
    run_steps("R9", 2);
    period_in[7:0]  = 8'd6;
    duty_in[7:0]    = 8'd3;
    duty_in[15:8]   = 8'd1;
    indep_sel[0]    = 1'b1;
    align_sel[1]    = 1'b0;
    run_steps("R9", 2);
    // Last clocks of the old cycle used period 4 and duty 2: channel 0 low, odd high.
    check("R9", {reload_out, pwm_out[1:0]}, {3'b000, 2'b10});
    run_steps("R9", 14);

    // R9: center-aligned switch of alignment and period mid-cycle.
    align_sel = 3'b000;
    period_in = {8'd0, 8'd0, 8'd3};
    duty_in   = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2};
    do_reset();
    run_steps("R9", 3);
    align_sel[0]   = 1'b1;
    period_in[7:0] = 8'd5;
    run_steps("R9 R2 R3", 20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule